// File: doc/BRIEF.md
# Key-Dependent Table Setup Sequencer

This block runs the key schedule of a Feistel cipher whose subkey array and four substitution tables depend on the key. When a new key is accepted, it first walks the 18 subkeys and XORs each one with a 32-bit word of the key. The key words are taken in turn and wrap around at the programmed key length. It then drives an external round engine again and again on one chained 64-bit block. Each 64-bit result is written back as two 32-bit entries, in order, over the subkeys and then over the four substitution tables. Later encryptions read those overwritten entries.

The tables live outside the block and hold their fixed initial constants before setup starts. Those constants are loaded by other logic. The sequencer owns one write port that covers all five tables and one combinational read of the subkey table. It also drives a start/done handshake with the round engine, whose latency may vary. The key is captured when it is accepted, so the source is free to change once `ready_o` has fallen.

Top module: `bks_key_sched`

## Requirements
- R1: While reset is held and once it is released, `ready_o` is 1, and `mem_we_o` and `eng_start_o` are 0.
- R2: `new_key_i` is acted on only in a cycle where `ready_o` is 1. Pulses while `ready_o` is 0 leave the result unchanged, and `ready_o` falls only in the cycle after an accepted `new_key_i`.
- R3: The first 18 writes go to table code 0 (subkeys), at addresses 0 to 17 in order. Entry i receives its old value (read through `p_rdata_i`) XOR key word (i mod n). Word j is `key_i[447-32j -: 32]`, so word 0 is the most significant 32 bits.
- R4: The word count n equals `key_words_i` for values 1 to 14. The values 0 and 15 select n = 14.
- R5: The key and the word count are sampled only in the accepting cycle. Later changes on `key_i` and `key_words_i` have no effect.
- R6: The block sent with the first engine start after a key is accepted is all zeros. Every later start sends the previous engine result unchanged.
- R7: After the XOR pass, each engine result makes two writes in consecutive cycles: bits 63:32 first, then bits 31:0. The addresses run over subkeys 0 to 17 (code 0), then table codes 1, 2, 3, 4 at addresses 0 to 255 each, for 1060 writes in total.
- R8: `eng_start_o` is high for exactly one cycle per block, and there are exactly 521 starts per key setup.
- R9: With an engine that raises `eng_done_i` L cycles after the cycle in which it saw `eng_start_o`, `ready_o` stays low for exactly 19 + 521·(L+3) cycles.
- R10: While `ready_o` is 1, there is no table write and no engine start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_i | input | 448 | Key, zero-padded, word 0 in the top 32 bits |
| key_words_i | input | 4 | Key length in 32-bit words (0 and 15 mean 14) |
| new_key_i | input | 1 | Request a key setup; taken only while ready_o is high |
| ready_o | output | 1 | Idle and able to accept a key |
| mem_we_o | output | 1 | Table write strobe |
| mem_tbl_o | output | 3 | Table code: 0 subkeys, 1 to 4 substitution tables |
| mem_addr_o | output | 8 | Entry index inside the selected table |
| mem_wdata_o | output | 32 | Write data |
| p_rdata_i | input | 32 | Subkey entry at mem_addr_o (combinational read) |
| eng_start_o | output | 1 | One-cycle start pulse to the round engine |
| eng_block_o | output | 64 | Block to encrypt, valid with eng_start_o |
| eng_done_i | input | 1 | One-cycle pulse, engine result valid |
| eng_result_i | input | 64 | Engine output block |

## Verification
The properties check the following on every cycle:
- no writes or starts are issued while idle;
- the start pulse lasts one cycle, and there are exactly 521 starts per setup;
- the chain starts from a zero block and passes each result on;
- the upper half of each result is written before the lower half.

The following only show up in the bench scenarios:
- the key-word wrap at each length, including the 0 and 15 cases;
- the capture of key and length at acceptance, and the ignored requests while busy;
- the exact address order;
- the total busy time.

The bench checks these by comparing all 1042 final table entries against a model of the schedule, and by counting cycles and write addresses.

// File: rtl/bks_pkg.sv
package bks_pkg;
  localparam int KEY_BITS  = 448;
  localparam int WORD_BITS = 32;
  localparam int P_COUNT   = 18;
  localparam int S_COUNT   = 4;
  localparam int S_DEPTH   = 256;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XOR,
    ST_START,
    ST_WAIT,
    ST_WR_L,
    ST_WR_R,
    ST_DONE
  } ks_state_e;
endpackage

// File: rtl/bks_key_words.sv
module bks_key_words #(
  parameter int KEY_W       = 448,
  parameter int WORD_W      = 32,
  parameter int FIXED_WORDS = 0,
  localparam int MAX_WORDS  = KEY_W / WORD_W,
  localparam int SZ_W       = $clog2(MAX_WORDS + 1),
  localparam int IDX_W      = $clog2(MAX_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [KEY_W-1:0]  key_i,
  input  logic [SZ_W-1:0]   size_i,
  input  logic              step_i,
  output logic [WORD_W-1:0] word_o
);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(MAX_WORDS - 1);

  logic [MAX_WORDS-1:0][WORD_W-1:0] key_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] last_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     key_q <= '0;
    else if (load_i) key_q <= key_i;
  end

  generate
    if (FIXED_WORDS == 0) begin : g_runtime
      logic [IDX_W-1:0] last_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) last_q <= TOP_IDX;
        else if (load_i)
          last_q <= (size_i == '0 || size_i > SZ_W'(MAX_WORDS))
                    ? TOP_IDX : IDX_W'(size_i - 1'b1);
      end
      assign last_w = last_q;
    end else begin : g_fixed
      // length known at build time: wrap point is a constant
      assign last_w = IDX_W'(FIXED_WORDS - 1);
    end
  endgenerate

  // wrapping counter replaces i mod n
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (load_i)  idx_q <= '0;
    else if (step_i)  idx_q <= (idx_q == last_w) ? '0 : idx_q + 1'b1;
  end

  assign word_o = key_q[TOP_IDX - idx_q];
endmodule

// File: rtl/bks_addr_gen.sv
module bks_addr_gen #(
  parameter int P_ENTRIES = 18,
  parameter int S_TABLES  = 4,
  parameter int S_ENTRIES = 256,
  localparam int TBL_W    = $clog2(S_TABLES + 1),
  localparam int IDX_W    = $clog2((S_ENTRIES > P_ENTRIES) ? S_ENTRIES : P_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  output logic [TBL_W-1:0] tbl_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             p_last_o,
  output logic             all_last_o
);
  localparam logic [IDX_W-1:0] P_END = IDX_W'(P_ENTRIES - 1);
  localparam logic [IDX_W-1:0] S_END = IDX_W'(S_ENTRIES - 1);
  localparam logic [TBL_W-1:0] T_END = TBL_W'(S_TABLES);

  logic [TBL_W-1:0] tbl_q;
  logic [IDX_W-1:0] idx_q;
  logic in_p, row_end;

  assign in_p    = (tbl_q == '0);
  assign row_end = in_p ? (idx_q == P_END) : (idx_q == S_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tbl_q <= '0;
      idx_q <= '0;
    end else if (clear_i) begin
      tbl_q <= '0;
      idx_q <= '0;
    end else if (step_i) begin
      idx_q <= row_end ? '0 : idx_q + 1'b1;
      if (row_end) tbl_q <= tbl_q + 1'b1;
    end
  end

  assign tbl_o      = tbl_q;
  assign idx_o      = idx_q;
  assign p_last_o   = in_p && (idx_q == P_END);
  assign all_last_o = (tbl_q == T_END) && (idx_q == S_END);
endmodule

// File: rtl/bks_fsm.sv
module bks_fsm
  import bks_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      new_key_i,
  input  logic      eng_done_i,
  input  logic      p_last_i,
  input  logic      all_last_i,
  output ks_state_e state_o,
  output logic      ready_o,
  output logic      load_o,
  output logic      clear_o,
  output logic      step_o,
  output logic      word_step_o,
  output logic      we_o,
  output logic      start_o,
  output logic      capture_o
);
  ks_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d     = state_q;
    ready_o     = 1'b0;
    load_o      = 1'b0;
    clear_o     = 1'b0;
    step_o      = 1'b0;
    word_step_o = 1'b0;
    we_o        = 1'b0;
    start_o     = 1'b0;
    capture_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        ready_o = 1'b1;
        if (new_key_i) begin
          load_o  = 1'b1;
          clear_o = 1'b1;
          state_d = ST_XOR;
        end
      end
      ST_XOR: begin
        we_o        = 1'b1;
        step_o      = 1'b1;
        word_step_o = 1'b1;
        if (p_last_i) begin
          clear_o = 1'b1;   // rewind to subkey 0 for the write-back pass
          state_d = ST_START;
        end
      end
      ST_START: begin
        start_o = 1'b1;
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (eng_done_i) begin
          capture_o = 1'b1;
          state_d   = ST_WR_L;
        end
      end
      ST_WR_L: begin
        we_o    = 1'b1;
        step_o  = 1'b1;
        state_d = ST_WR_R;
      end
      ST_WR_R: begin
        we_o    = 1'b1;
        step_o  = 1'b1;
        state_d = all_last_i ? ST_DONE : ST_START;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign state_o = state_q;
endmodule

// File: rtl/bks_key_sched.sv
module bks_key_sched
  import bks_pkg::*;
#(
  parameter int KEY_W       = KEY_BITS,
  parameter int WORD_W      = WORD_BITS,
  parameter int P_ENTRIES   = P_COUNT,
  parameter int S_TABLES    = S_COUNT,
  parameter int S_ENTRIES   = S_DEPTH,
  parameter int FIXED_WORDS = 0,
  localparam int MAX_WORDS  = KEY_W / WORD_W,
  localparam int SZ_W       = $clog2(MAX_WORDS + 1),
  localparam int TBL_W      = $clog2(S_TABLES + 1),
  localparam int IDX_W      = $clog2((S_ENTRIES > P_ENTRIES) ? S_ENTRIES : P_ENTRIES),
  localparam int BLK_W      = 2 * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [KEY_W-1:0]  key_i,
  input  logic [SZ_W-1:0]   key_words_i,
  input  logic              new_key_i,
  output logic              ready_o,
  output logic              mem_we_o,
  output logic [TBL_W-1:0]  mem_tbl_o,
  output logic [IDX_W-1:0]  mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] p_rdata_i,
  output logic              eng_start_o,
  output logic [BLK_W-1:0]  eng_block_o,
  input  logic              eng_done_i,
  input  logic [BLK_W-1:0]  eng_result_i
);
  ks_state_e         state;
  logic              load, clear, step, word_step, capture;
  logic              p_last, all_last;
  logic [WORD_W-1:0] key_word;
  logic [BLK_W-1:0]  block_q;

  bks_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .new_key_i  (new_key_i),
    .eng_done_i (eng_done_i),
    .p_last_i   (p_last),
    .all_last_i (all_last),
    .state_o    (state),
    .ready_o    (ready_o),
    .load_o     (load),
    .clear_o    (clear),
    .step_o     (step),
    .word_step_o(word_step),
    .we_o       (mem_we_o),
    .start_o    (eng_start_o),
    .capture_o  (capture)
  );

  bks_key_words #(
    .KEY_W      (KEY_W),
    .WORD_W     (WORD_W),
    .FIXED_WORDS(FIXED_WORDS)
  ) u_words (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .key_i (key_i),
    .size_i(key_words_i),
    .step_i(word_step),
    .word_o(key_word)
  );

  bks_addr_gen #(
    .P_ENTRIES(P_ENTRIES),
    .S_TABLES (S_TABLES),
    .S_ENTRIES(S_ENTRIES)
  ) u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear),
    .step_i    (step),
    .tbl_o     (mem_tbl_o),
    .idx_o     (mem_addr_o),
    .p_last_o  (p_last),
    .all_last_o(all_last)
  );

  // chained block: zero at key accept, then last engine result
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       block_q <= '0;
    else if (load)     block_q <= '0;
    else if (capture)  block_q <= eng_result_i;
  end

  assign eng_block_o = block_q;

  always_comb begin
    unique case (state)
      ST_XOR:  mem_wdata_o = p_rdata_i ^ key_word;
      ST_WR_L: mem_wdata_o = block_q[BLK_W-1:WORD_W];
      default: mem_wdata_o = block_q[WORD_W-1:0];
    endcase
  end
endmodule

// File: rtl/bks_checker.sv
module bks_checker
  import bks_pkg::*;
#(
  localparam int WW     = WORD_BITS,
  localparam int BW     = 2 * WORD_BITS,
  localparam int BLOCKS = (P_COUNT + S_COUNT * S_DEPTH) / 2,
  localparam int CNT_W  = $clog2(BLOCKS + 1) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          new_key_i,
  input logic          ready_o,
  input logic          mem_we_o,
  input logic [WW-1:0] mem_wdata_o,
  input logic          eng_start_o,
  input logic [BW-1:0] eng_block_o,
  input logic          eng_done_i,
  input logic [BW-1:0] eng_result_i
);
  logic [CNT_W-1:0] start_cnt;
  logic [BW-1:0]    res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_cnt <= '0;
    else if (ready_o && new_key_i) start_cnt <= '0;
    else if (eng_start_o) start_cnt <= start_cnt + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         res_q <= '0;
    else if (eng_done_i) res_q <= eng_result_i;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!mem_we_o && !eng_start_o)); // R10

  AST_FALL_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> $past(new_key_i)); // R2

  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |=> !eng_start_o); // R8

  AST_START_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (start_cnt == CNT_W'(BLOCKS))); // R8

  AST_FIRST_BLOCK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_start_o && start_cnt == '0) |-> (eng_block_o == '0)); // R6

  AST_CHAIN_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_start_o && start_cnt != '0) |-> (eng_block_o == res_q)); // R6

  AST_LEFT_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(eng_done_i)) |-> (mem_wdata_o == $past(eng_result_i[BW-1:WW]))); // R7

  AST_RIGHT_SECOND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(eng_done_i, 2)) |-> (mem_wdata_o == $past(eng_result_i[WW-1:0], 2))); // R7
endmodule

bind bks_key_sched bks_checker u_chk (.*);

// File: tb/sim_bks_key_sched.sv
module sim_bks_key_sched;
  localparam int ENG_LAT = 4;
  localparam int NBLK    = 521;
  localparam int NWR     = 18 + 2 * NBLK;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [447:0] key = '0;
  logic [3:0]   kwords = 4'd4;
  logic         new_key = 1'b0;
  logic         ready, mem_we, eng_start, eng_done;
  logic [2:0]   mem_tbl;
  logic [7:0]   mem_addr;
  logic [31:0]  mem_wdata, p_rdata;
  logic [63:0]  eng_block, eng_res;

  int n_chk = 0, n_fail = 0;
  int low_cnt, wr_cnt, order_err, start_cnt, idle_err;

  // set 0: tables seen by the design, set 1: reference model
  logic [31:0] p_arr [2][18];
  logic [31:0] s_arr [2][4][256];

  always #2 clk = ~clk;

  bks_key_sched u0 (
    .clk_i(clk), .rst_ni(rst_n), .key_i(key), .key_words_i(kwords),
    .new_key_i(new_key), .ready_o(ready), .mem_we_o(mem_we),
    .mem_tbl_o(mem_tbl), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .p_rdata_i(p_rdata), .eng_start_o(eng_start), .eng_block_o(eng_block),
    .eng_done_i(eng_done), .eng_result_i(eng_res)
  );

  assign p_rdata = (mem_addr < 8'd18) ? p_arr[0][mem_addr[4:0]] : 32'h0;

  function automatic logic [31:0] ff(int set, logic [31:0] x);
    return ((s_arr[set][0][x[31:24]] + s_arr[set][1][x[23:16]]) ^ s_arr[set][2][x[15:8]])
           + s_arr[set][3][x[7:0]];
  endfunction

  function automatic logic [63:0] bf_enc(int set, logic [63:0] b);
    logic [31:0] l, r, t;
    l = b[63:32];
    r = b[31:0];
    for (int i = 0; i < 16; i++) begin
      l = l ^ p_arr[set][i];
      r = r ^ ff(set, l);
      t = l; l = r; r = t;
    end
    t = l; l = r; r = t;
    r = r ^ p_arr[set][16];
    l = l ^ p_arr[set][17];
    return {l, r};
  endfunction

  function automatic logic [10:0] exp_pos(int k);
    int j;
    if (k < 18) return {3'd0, 8'(k)};
    j = k - 18;
    if (j < 18) return {3'd0, 8'(j)};
    j = j - 18;
    return {3'(1 + j / 256), 8'(j % 256)};
  endfunction

  // table memory written by the design
  always @(posedge clk) begin
    if (rst_n && mem_we) begin
      if (mem_tbl == 3'd0) p_arr[0][mem_addr[4:0]] = mem_wdata;
      else                 s_arr[0][mem_tbl - 3'd1][mem_addr] = mem_wdata;
    end
  end

  // round engine model, done ENG_LAT cycles after the start cycle
  logic       eng_busy;
  logic [2:0] eng_rem;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_busy <= 1'b0;
      eng_rem  <= '0;
      eng_res  <= '0;
    end else if (eng_start) begin
      eng_res  <= bf_enc(0, eng_block);
      eng_busy <= 1'b1;
      eng_rem  <= 3'(ENG_LAT - 1);
    end else if (eng_busy) begin
      if (eng_rem == 3'd0) eng_busy <= 1'b0;
      else                 eng_rem  <= eng_rem - 3'd1;
    end
  end
  assign eng_done = eng_busy && (eng_rem == 3'd0);

  always @(negedge clk) begin
    if (rst_n) begin
      if (!ready) low_cnt++;
      else if (mem_we || eng_start) idle_err++;
      if (mem_we) begin
        if ({mem_tbl, mem_addr} != exp_pos(wr_cnt)) order_err++;
        wr_cnt++;
      end
      if (eng_start) start_cnt++;
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic fill_tables(logic [31:0] seed);
    logic [31:0] v = seed;
    for (int i = 0; i < 18; i++) begin
      v = v * 32'd1664525 + 32'd1013904223;
      p_arr[0][i] = v; p_arr[1][i] = v;
    end
    for (int t = 0; t < 4; t++)
      for (int e = 0; e < 256; e++) begin
        v = v * 32'd1664525 + 32'd1013904223;
        s_arr[0][t][e] = v; s_arr[1][t][e] = v;
      end
  endtask

  task automatic put_ref(int pos, logic [31:0] v);
    if (pos < 18) p_arr[1][pos] = v;
    else          s_arr[1][(pos - 18) / 256][(pos - 18) % 256] = v;
  endtask

  task automatic ref_sched(logic [447:0] k, logic [3:0] w);
    int n;
    logic [63:0] blk;
    n = (w == 4'd0 || w > 4'd14) ? 14 : int'(w);
    for (int i = 0; i < 18; i++) p_arr[1][i] ^= k[447 - 32 * (i % n) -: 32];
    blk = '0;
    for (int b = 0; b < NBLK; b++) begin
      blk = bf_enc(1, blk);
      put_ref(2 * b, blk[63:32]);
      put_ref(2 * b + 1, blk[31:0]);
    end
  endtask

  function automatic logic [447:0] rnd_key();
    logic [447:0] k;
    for (int i = 0; i < 14; i++) k[i * 32 +: 32] = $urandom;
    return k;
  endfunction

  task automatic run_key(logic [447:0] k, logic [3:0] w, bit disturb, string tag);
    int guard, p_bad, s_bad;
    fill_tables($urandom);
    ref_sched(k, w);
    low_cnt = 0; wr_cnt = 0; order_err = 0; start_cnt = 0; idle_err = 0;
    @(posedge clk); #1;
    key = k; kwords = w; new_key = 1'b1;
    @(posedge clk); #1;
    new_key = 1'b0;
    key = rnd_key();                 // R5: source changes after accept
    kwords = 4'($urandom);
    if (disturb) begin               // R2: requests while busy
      repeat (50) @(posedge clk); #1;
      new_key = 1'b1; key = rnd_key(); kwords = 4'd1;
      repeat (3) @(posedge clk); #1;
      new_key = 1'b0;
    end
    guard = 0;
    @(negedge clk);
    while (!ready && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    #1;
    p_bad = 0; s_bad = 0;
    for (int i = 0; i < 18; i++) if (p_arr[0][i] !== p_arr[1][i]) p_bad++;
    for (int t = 0; t < 4; t++)
      for (int e = 0; e < 256; e++) if (s_arr[0][t][e] !== s_arr[1][t][e]) s_bad++;
    chk(guard < 20000, {tag, " R9"}, "ready returned", guard, 0);
    chk(low_cnt == 19 + NBLK * (3 + ENG_LAT), {tag, " R9"}, "busy cycles",
        low_cnt, 19 + NBLK * (3 + ENG_LAT));
    chk(order_err == 0 && wr_cnt == NWR, {tag, " R7"}, "write order errors/count",
        order_err * 100000 + wr_cnt, NWR);
    chk(start_cnt == NBLK, {tag, " R8"}, "engine starts", start_cnt, NBLK);
    chk(p_bad == 0, {tag, " R3"}, "subkey mismatches", p_bad, 0);
    chk(s_bad == 0, {tag, " R6"}, "table mismatches", s_bad, 0);
    chk(idle_err == 0, {tag, " R10"}, "activity while ready", idle_err, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    void'($urandom(32'd7031));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ready === 1'b1 && mem_we === 1'b0 && eng_start === 1'b0, "R1", "in reset",
        {ready, mem_we, eng_start}, 3'b100);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(ready === 1'b1 && mem_we === 1'b0 && eng_start === 1'b0, "R1", "after reset",
        {ready, mem_we, eng_start}, 3'b100);
    run_key(rnd_key(), 4'd4, 1'b0, "R3 size4");
    run_key(rnd_key(), 4'd1, 1'b0, "R3 size1");
    run_key(rnd_key(), 4'd14, 1'b1, "R2 R5 size14");
    run_key(rnd_key(), 4'd0, 1'b0, "R4 size0");
    run_key(rnd_key(), 4'd15, 1'b0, "R4 size15");
    run_key(rnd_key(), 4'd7, 1'b0, "R5 size7");
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end
endmodule